// File: doc/BRIEF.md
# ADC Sample FIFO with Interrupt Request

This block sits between an analog-to-digital converter's sample stream and a small register bus. Each accepted 16-bit sample, which carries its channel tag in its upper bits, is written into a first-in first-out buffer. Software drains the buffer by reading a data address, and each such read removes one sample. A status word combines the current control byte with four flags: empty, at least half full, overflow, and interrupt pending.

An interrupt request is raised either for every accepted sample or when the fill level first reaches half the depth. Bit 5 of the control byte selects between these two sources, and bit 4 enables them. The request is latched and stays asserted until software writes to a dedicated clear-interrupt address. A separate clear-buffer address discards all stored samples and the overflow condition. Overflow is treated as fatal. Once the buffer has filled, it stops accepting samples until it is cleared, even if reads drain it in the meantime.

The bus uses four addresses. Address 0 reads as sample data and pops one sample. Address 1 is written as the control byte and reads back as the status word. A write of any value to address 2 clears the interrupt. A write of any value to address 3 clears the buffer. The depth is a power-of-two parameter, typically 1024 or 4096.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the buffer is empty, the status word reads 16'h0100 (only the empty bit, bit 8, set) and `irq` is low.
- R2: Samples are returned in arrival order, and a read of address 0 while `bus_rd` is high removes exactly one sample.
- R3: Status bit 8 is 1 when the buffer holds no samples. Status bit 9 is 1 when it holds DEPTH/2 or more samples.
- R4: Status bit 10 sets when an accepted sample brings the buffer to DEPTH samples. It then stays set until a clear-buffer write, and samples offered while it is set are dropped, even after reads have made space.
- R5: A write to address 1 loads the control byte from `bus_wdata`, and status bits 7:0 read back that byte. Status bits 15:12 read 0.
- R6: With control bit 4 = 1 and bit 5 = 0, every accepted sample sets the pending flag (status bit 11), which drives `irq` high from the next cycle.
- R7: With control bit 4 = 1 and bit 5 = 1, the pending flag sets only in the cycle where the fill level moves from below DEPTH/2 to DEPTH/2 or more.
- R8: Once set, the pending flag stays set until a write to address 2. If a new interrupt event occurs in the same cycle as that write, the flag stays set.
- R9: With control bit 4 = 0, no event sets the pending flag.
- R10: A write to address 3 empties the buffer and clears status bit 10 from the next cycle, drops any sample offered in that cycle, and leaves the pending flag unchanged.
- R11: A read of address 0 while the buffer is empty returns the most recently popped sample (0 after reset) and leaves the buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Tagged sample word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 0) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data (control byte) |
| bus_rdata | output | 16 | Read data: sample at address 0, status at address 1, else 0 |
| irq | output | 1 | Latched interrupt request |

## Verification
The hardest state to reach from the ports is a buffer that has overflowed and then been partly drained, where the bench must confirm that new samples are still refused. The stimulus fills the buffer with back-to-back samples, offers one more, pops one and offers another. The bench then checks that the level and the overflow bit do not move. It also drives a sample and a clear-interrupt write in the same cycle, to exercise the rule that a set and a clear arriving together leave the request set. A long randomized phase follows, mixing samples, pops, clears and mode changes. A queue-based model is compared against the design on every clock throughout.

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int DEPTH = 1024,
  parameter int AW    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] HALF_C = (PW+1)'(DEPTH / 2);
  localparam logic [PW:0] FULL_C = (PW+1)'(DEPTH);
  localparam logic [AW-1:0] A_DATA   = AW'(0);
  localparam logic [AW-1:0] A_CTRL   = AW'(1);
  localparam logic [AW-1:0] A_CLRIRQ = AW'(2);
  localparam logic [AW-1:0] A_CLRBUF = AW'(3);

  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt, cnt_n;
  logic          full_q, pend_q;
  logic [7:0]    ctrl_q;
  logic [15:0]   last_q;

  wire clr_buf = bus_wr && (bus_addr == A_CLRBUF);
  wire clr_irq = bus_wr && (bus_addr == A_CLRIRQ);
  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire push    = smp_valid && !full_q && !clr_buf;
  wire pop     = bus_rd && (bus_addr == A_DATA) && (cnt != '0);
  wire empty   = (cnt == '0);
  wire half    = (cnt >= HALF_C);

  always_comb begin
    if (clr_buf) cnt_n = '0;
    else cnt_n = cnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
  end

  wire half_hit = (cnt < HALF_C) && (cnt_n >= HALF_C);
  wire irq_evt  = ctrl_q[4] && (ctrl_q[5] ? half_hit : push);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= smp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      full_q <= 1'b0; pend_q <= 1'b0;
      ctrl_q <= '0; last_q <= '0;
    end else begin
      cnt <= cnt_n;
      if (pop) last_q <= mem[rp];
      if (clr_buf) begin
        wp <= '0; rp <= '0; full_q <= 1'b0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        if (push && cnt_n == FULL_C) full_q <= 1'b1;
      end
      if (irq_evt)      pend_q <= 1'b1;
      else if (clr_irq) pend_q <= 1'b0;
      if (ctrl_wr) ctrl_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = empty ? last_q : mem[rp];
      A_CTRL:  bus_rdata = {4'b0, pend_q, full_q, half, empty, ctrl_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = pend_q;

  a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !clr_buf |=> full_q);
  a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> cnt <= $past(cnt));
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq);
  a_r9_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !ctrl_q[4] |=> !irq);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_buf |=> empty && !full_q);
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !smp_valid |=> empty);
  a_r6_each_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] && !ctrl_q[5] && smp_valid && !full_q && !clr_buf |=> irq);
endmodule

// File: tb/adc_sample_fifo_tb.sv
module adc_sample_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] smp_data = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq;

  adc_sample_fifo #(.DEPTH(DEPTH), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  int q[$];
  bit m_full, m_pend;
  logic [7:0] m_ctrl;
  logic [15:0] m_last;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_full = 0; m_pend = 0; m_ctrl = 0; m_last = 0;
    end else begin
      bit clr, ci, cw, pop, push, ev;
      int old;
      clr  = bus_wr && bus_addr == 3;
      ci   = bus_wr && bus_addr == 2;
      cw   = bus_wr && bus_addr == 1;
      old  = q.size();
      pop  = bus_rd && bus_addr == 0 && old > 0;
      push = smp_valid && !m_full && !clr;
      if (pop) m_last = 16'(q.pop_front());
      if (push) q.push_back(int'(smp_data));
      if (clr) begin q.delete(); m_full = 0; end
      else if (push && q.size() == DEPTH) m_full = 1;
      ev = m_ctrl[4] && (m_ctrl[5] ? (old < HALF && q.size() >= HALF) : push);
      if (ev) m_pend = 1; else if (ci) m_pend = 0;
      if (cw) m_ctrl = bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_status();
    return {4'b0, m_pend, m_full, q.size() >= HALF, q.size() == 0, m_ctrl};
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R8 irq vs pending", {15'b0, irq}, {15'b0, m_pend});
      if (bus_addr == 0)
        chk("R2 data word", bus_rdata, (q.size() > 0) ? 16'(q[0]) : m_last);
      else if (bus_addr == 1)
        chk("R3 status word", bus_rdata, m_status());
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask
  task automatic put(input logic [15:0] d);
    smp_valid = 1; smp_data = d; @(negedge clk); smp_valid = 0;
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; @(negedge clk); bus_wr = 0; bus_addr = 1;
  endtask
  task automatic pop(output logic [15:0] v);
    bus_rd = 1; bus_addr = 0; #1 v = bus_rdata; @(negedge clk); bus_rd = 0; bus_addr = 1;
  endtask
  task automatic peek(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a; #1 v = bus_rdata; #1 bus_addr = 1;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bus_addr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    peek(1, v); chk("R1 reset status", v, 16'h0100);
    chk("R1 reset irq", {15'b0, irq}, 16'h0);
    peek(0, v); chk("R11 empty read after reset", v, 16'h0000);

    wr(1, 8'h10);
    peek(1, v); chk("R5 control readback", v, 16'h0110);
    put(16'hA001);
    chk("R6 irq after one sample", {15'b0, irq}, 16'h1);
    put(16'hB002); put(16'hC003);
    peek(1, v); chk("R6 status pending", v, 16'h0810);
    pop(v); chk("R2 first out", v, 16'hA001);
    pop(v); chk("R2 second out", v, 16'hB002);
    pop(v); chk("R2 third out", v, 16'hC003);
    pop(v); chk("R11 empty read returns last", v, 16'hC003);
    peek(1, v); chk("R3 empty again", v, 16'h0910);
    idle();
    chk("R8 irq held without clear", {15'b0, irq}, 16'h1);
    wr(2, 8'h5A);
    chk("R8 irq cleared", {15'b0, irq}, 16'h0);

    wr(1, 8'h30);
    for (int i = 0; i < HALF - 1; i++) put(16'h1000 + 16'(i));
    chk("R7 no irq below half", {15'b0, irq}, 16'h0);
    put(16'h1000 + 16'(HALF - 1));
    chk("R7 irq at half", {15'b0, irq}, 16'h1);
    peek(1, v); chk("R3 half bit", v, 16'h0A30);
    wr(2, 8'h00);
    for (int i = HALF; i < DEPTH; i++) put(16'h1000 + 16'(i));
    peek(1, v); chk("R4 full set", v, 16'h0630);
    put(16'hDEAD);
    pop(v); chk("R2 order after fill", v, 16'h1000);
    put(16'hBEEF);
    peek(1, v); chk("R4 still full after pop", v, 16'h0630);
    for (int i = 1; i < DEPTH; i++) begin
      pop(v);
      if (i == DEPTH - 1) chk("R4 dropped sample absent", v, 16'h1000 + 16'(DEPTH - 1));
    end
    peek(1, v); chk("R4 full stays while empty", v, 16'h0530);
    put(16'h7777);
    peek(1, v); chk("R4 refused while flagged", v, 16'h0530);
    wr(3, 8'h00);
    peek(1, v); chk("R10 clear restores empty", v, 16'h0130);

    wr(1, 8'h10);
    put(16'h4444);
    wr(3, 8'hFF);
    peek(1, v); chk("R10 clear keeps pending", v, 16'h0910);
    smp_valid = 1; smp_data = 16'h5555; bus_wr = 1; bus_addr = 3;
    @(negedge clk); smp_valid = 0; bus_wr = 0; bus_addr = 1;
    peek(1, v); chk("R10 sample dropped on clear", v, 16'h0910);
    wr(2, 8'h00);

    wr(1, 8'h20);
    for (int i = 0; i < HALF + 2; i++) put(16'h2000 + 16'(i));
    chk("R9 no irq when disabled", {15'b0, irq}, 16'h0);
    peek(1, v); chk("R9 status without pending", v, 16'h0220);
    wr(3, 8'h00);

    wr(1, 8'h10);
    smp_valid = 1; smp_data = 16'h3333; bus_wr = 1; bus_addr = 2;
    @(negedge clk); smp_valid = 0; bus_wr = 0; bus_addr = 1;
    chk("R8 set wins over clear", {15'b0, irq}, 16'h1);
    wr(2, 8'h00);
    chk("R8 plain clear", {15'b0, irq}, 16'h0);
    wr(3, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      smp_valid = ($urandom_range(0, 2) != 0);
      smp_data = 16'($urandom);
      bus_wr = 0; bus_rd = 0; bus_addr = 1;
      if (r < 40) begin bus_rd = 1; bus_addr = 0; end
      else if (r < 43) begin bus_wr = 1; bus_addr = 3; end
      else if (r < 50) begin bus_wr = 1; bus_addr = 2; end
      else if (r < 52) begin bus_wr = 1; bus_addr = 1; bus_wdata = 8'($urandom) | 8'h10; end
      else if (r < 70) bus_addr = 0;
      @(negedge clk);
    end
    smp_valid = 0; bus_wr = 0; bus_rd = 0; bus_addr = 1;
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule